// File: doc/BRIEF.md
# Burst Register Target for a Multiplexed Address/Data Bus

This block is a bus target that serves a small bank of 32-bit registers over a parallel bus. One set of 32 wires carries the address and then the data. A second set of four wires carries first the command and then active-low byte enables. When the initiator starts a cycle, the block looks at the command and address, or at its configuration select line. If the access is its own, it drives its select response and runs data phases with its ready signal. Each completed phase writes the enabled byte lanes, or places a register on the data output.

Bursts step one register (four bytes) per completed phase. If a burst would run past the last register, the block asks the initiator to stop. After the final phase, the control outputs are driven inactive for one clock and then released. An initiator-side or central parity unit, arbitration, locking and interrupts live elsewhere.

Top module: `mbus_target`

## Requirements
- R1: While reset (active low, asynchronous) is asserted, and after it is released with the bus idle, `ctlOe` and `adOe` are 0 and `devselN`, `trdyN` and `stopN` are 1.
- R2: An address phase is the first clock where `frameN` is sampled low after being high. A memory read (`cbeN`=0110) or memory write (0111) is claimed when address bits [31:5] equal `MEM_BASE` bits [31:5]. With the default of 8 registers, address bits [4:2] pick the register. In the clock after the address phase, `devselN` and `trdyN` are 0. An out-of-range address is not claimed, and `ctlOe` stays 0.
- R3: I/O read (0010) and I/O write (0011) are claimed when address bits [31:5] equal `IO_BASE` bits [31:5]. The address is a byte address, so bits [1:0] are ignored and bits [4:2] pick the register.
- R4: Configuration read (1010) and configuration write (1011) are claimed only while `idsel` is 1 in the address phase. The address is not range-checked, and bits [4:2] pick the register. With `idsel` at 0 the access is ignored.
- R5: On a write phase that completes, byte k of the selected register (bits 8k+7:8k) takes `adIn` only when `cbeN[k]` is 0. The other bytes keep their values.
- R6: During a read data phase, `adOe` is 1 and `adOut` equals the selected register. A write completed earlier is visible to a later read.
- R7: A clock with `trdyN` low and `irdyN` high is a wait: no byte is written, the register index holds, and `trdyN` stays low.
- R8: Each completed phase with `frameN` still low advances the register index by one.
- R9: When a phase completes at the last register with `frameN` still low, the next clock has `stopN`=0, `trdyN`=1 and `devselN`=0. This holds until `frameN` is sampled high, and no register is written meanwhile.
- R10: In the clock after the final phase (completed with `frameN` high), or after STOP ends, `devselN`, `trdyN` and `stopN` are 1 with `ctlOe`=1. In the clock after that, `ctlOe` is 0.
- R11: Any other command code (for example 0000) is never claimed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| frameN | input | 1 | Cycle frame from initiator, active low |
| irdyN | input | 1 | Initiator ready, active low |
| idsel | input | 1 | Configuration select, active high |
| adIn | input | 32 | Address/data bus as seen by the target |
| cbeN | input | 4 | Command in address phase, byte enables (active low) in data phases |
| devselN | output | 1 | Device-select response, active low |
| trdyN | output | 1 | Target ready, active low |
| stopN | output | 1 | Stop request to initiator, active low |
| ctlOe | output | 1 | Drive enable for devselN, trdyN and stopN (0 = high impedance) |
| adOut | output | 32 | Read data |
| adOe | output | 1 | Drive enable for adOut |

## Verification
Memory, I/O and configuration commands each write and read back through bursts. A mismatch between them shows up as a misrouted register, which separates the three decode paths and the byte-address handling of I/O. Partial byte-enable masks separate per-lane writes from whole-word writes. A wait cycle carrying garbage data with all lanes enabled shows whether a stalled phase is wrongly committed. Out-of-range, unselected-configuration and unknown-command cycles followed by readback show that ignored cycles leave the bank alone. A write burst that runs off the end of the bank tells a STOP disconnect apart from a silent wrap to register 0.

// File: rtl/mbus_pkg.sv
`timescale 1ns/1ps
package mbus_pkg;

  localparam logic [3:0] CMD_IO_RD  = 4'b0010;
  localparam logic [3:0] CMD_IO_WR  = 4'b0011;
  localparam logic [3:0] CMD_MEM_RD = 4'b0110;
  localparam logic [3:0] CMD_MEM_WR = 4'b0111;
  localparam logic [3:0] CMD_CFG_RD = 4'b1010;
  localparam logic [3:0] CMD_CFG_WR = 4'b1011;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DATA,
    ST_STOP,
    ST_TURN
  } tgtState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadIdx;
    logic incIdx;
    logic wrEn;
  } dpStrobe_t;

endpackage

// File: rtl/mbus_datapath.sv
`timescale 1ns/1ps
module mbus_datapath
  import mbus_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        stb,
  input  logic [IDX_W-1:0] startIdx,
  input  logic [31:0]      wrData,
  input  logic [3:0]       byteEnN,
  output logic [31:0]      rdData,
  output logic             atLast
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REGS - 1);

  logic [IDX_W-1:0] curIdx;
  logic [31:0]      bank [NUM_REGS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curIdx <= '0;
    end else if (stb.loadIdx) begin
      curIdx <= startIdx;
    end else if (stb.incIdx) begin
      curIdx <= curIdx + 1'b1;
    end
  end

  // one write-enable per register and byte lane
  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    for (genvar b = 0; b < 4; b++) begin : g_lane
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          bank[r][8*b +: 8] <= 8'h00;
        end else if (stb.wrEn && !byteEnN[b] && (curIdx == IDX_W'(r))) begin
          bank[r][8*b +: 8] <= wrData[8*b +: 8];
        end
      end
    end
  end

  assign rdData = bank[curIdx];
  assign atLast = (curIdx == LAST_IDX);

endmodule

// File: rtl/mbus_ctrl.sv
`timescale 1ns/1ps
module mbus_ctrl
  import mbus_pkg::*;
#(
  parameter int          NUM_REGS = 8,
  parameter int          IDX_W    = $clog2(NUM_REGS),
  parameter logic [31:0] MEM_BASE = 32'h4000_0000,
  parameter logic [31:0] IO_BASE  = 32'h0000_1000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameN,
  input  logic             irdyN,
  input  logic             idsel,
  input  logic [29:0]      addrWord,
  input  logic [3:0]       cmd,
  input  logic             atLast,
  output dpStrobe_t        stb,
  output logic [IDX_W-1:0] startIdx,
  output logic             devselN,
  output logic             trdyN,
  output logic             stopN,
  output logic             ctlOe,
  output logic             adOe
);

  // span of the bank in bytes is 2**SPAN_W; addrWord is address bits [31:2]
  localparam int SPAN_W = IDX_W + 2;

  tgtState_t state, nextState;
  logic      prevFrameN;
  logic      isWrite;
  logic      addrPhase;
  logic      memHit, ioHit, cfgHit, claim;

  assign addrPhase = !frameN && prevFrameN && (state == ST_IDLE);
  assign startIdx  = addrWord[IDX_W-1:0];

  always_comb begin
    memHit = ((cmd == CMD_MEM_RD) || (cmd == CMD_MEM_WR)) &&
             (addrWord[29:SPAN_W-2] == MEM_BASE[31:SPAN_W]);
    ioHit  = ((cmd == CMD_IO_RD) || (cmd == CMD_IO_WR)) &&
             (addrWord[29:SPAN_W-2] == IO_BASE[31:SPAN_W]);
    cfgHit = ((cmd == CMD_CFG_RD) || (cmd == CMD_CFG_WR)) && idsel;
    claim  = memHit || ioHit || cfgHit;
  end

  always_comb begin
    nextState = state;
    stb       = '0;
    unique case (state)
      ST_IDLE: begin
        if (addrPhase && claim) begin
          stb.loadIdx = 1'b1;
          nextState   = ST_DATA;
        end
      end
      ST_DATA: begin
        if (!irdyN) begin
          stb.wrEn = isWrite;
          if (frameN) begin
            nextState = ST_TURN;
          end else if (atLast) begin
            nextState = ST_STOP;
          end else begin
            stb.incIdx = 1'b1;
          end
        end
      end
      ST_STOP: begin
        if (frameN) nextState = ST_TURN;
      end
      ST_TURN: nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      prevFrameN <= 1'b1;
      isWrite    <= 1'b0;
    end else begin
      state      <= nextState;
      prevFrameN <= frameN;
      if (stb.loadIdx) isWrite <= cmd[0];
    end
  end

  always_comb begin
    devselN = !((state == ST_DATA) || (state == ST_STOP));
    trdyN   = (state != ST_DATA);
    stopN   = (state != ST_STOP);
    ctlOe   = (state != ST_IDLE);
    adOe    = (state == ST_DATA) && !isWrite;
  end

endmodule

// File: rtl/mbus_target.sv
`timescale 1ns/1ps
module mbus_target
  import mbus_pkg::*;
#(
  parameter int          NUM_REGS = 8,
  parameter logic [31:0] MEM_BASE = 32'h4000_0000,
  parameter logic [31:0] IO_BASE  = 32'h0000_1000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        frameN,
  input  logic        irdyN,
  input  logic        idsel,
  input  logic [31:0] adIn,
  input  logic [3:0]  cbeN,
  output logic        devselN,
  output logic        trdyN,
  output logic        stopN,
  output logic        ctlOe,
  output logic [31:0] adOut,
  output logic        adOe
);

  localparam int IDX_W = $clog2(NUM_REGS);

  dpStrobe_t        stb;
  logic [IDX_W-1:0] startIdx;
  logic             atLast;

  mbus_ctrl #(
    .NUM_REGS (NUM_REGS),
    .IDX_W    (IDX_W),
    .MEM_BASE (MEM_BASE),
    .IO_BASE  (IO_BASE)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .frameN   (frameN),
    .irdyN    (irdyN),
    .idsel    (idsel),
    .addrWord (adIn[31:2]),
    .cmd      (cbeN),
    .atLast   (atLast),
    .stb      (stb),
    .startIdx (startIdx),
    .devselN  (devselN),
    .trdyN    (trdyN),
    .stopN    (stopN),
    .ctlOe    (ctlOe),
    .adOe     (adOe)
  );

  mbus_datapath #(
    .NUM_REGS (NUM_REGS),
    .IDX_W    (IDX_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .startIdx (startIdx),
    .wrData   (adIn),
    .byteEnN  (cbeN),
    .rdData   (adOut),
    .atLast   (atLast)
  );

endmodule

// File: rtl/mbus_target_chk.sv
`timescale 1ns/1ps
module mbus_target_chk (
  input logic        clk,
  input logic        rstN,
  input logic        frameN,
  input logic        irdyN,
  input logic        devselN,
  input logic        trdyN,
  input logic        stopN,
  input logic        ctlOe,
  input logic [31:0] adOut,
  input logic        adOe
);

  // R10: final completed phase -> one clock driven inactive, then released
  assert_release_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!trdyN && !irdyN && frameN) |=> (devselN && trdyN && stopN && ctlOe));

  assert_float_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!trdyN && !irdyN && frameN) |-> ##2 !ctlOe);

  // R7: read data holds across a wait clock
  assert_wait_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (adOe && irdyN) |=> $stable(adOut));

  // R9: stop persists while the initiator keeps the frame
  assert_stop_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!stopN && !frameN) |=> (!stopN && trdyN));

  // R2: select response only follows a clock with frame asserted
  assert_select_after_frame_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(devselN) |-> $past(!frameN));

  // R6: read data is driven only under an active select
  assert_read_selected_R6: assert property (@(posedge clk) disable iff (!rstN)
    adOe |-> (!devselN && ctlOe));

endmodule

bind mbus_target mbus_target_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .frameN  (frameN),
  .irdyN   (irdyN),
  .devselN (devselN),
  .trdyN   (trdyN),
  .stopN   (stopN),
  .ctlOe   (ctlOe),
  .adOut   (adOut),
  .adOe    (adOe)
);

// File: tb/sim_mbus_target.sv
`timescale 1ns/1ps
module sim_mbus_target;

  localparam logic [31:0] MEM_BASE = 32'h4000_0000;
  localparam logic [31:0] IO_BASE  = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameN = 1'b1;
  logic        irdyN = 1'b1;
  logic        idsel = 1'b0;
  logic [31:0] adIn = '0;
  logic [3:0]  cbeN = 4'hF;
  logic        devselN, trdyN, stopN, ctlOe, adOe;
  logic [31:0] adOut;

  int          nTests = 0;
  int          nFails = 0;
  bit          finished = 1'b0;
  logic [31:0] model [8];

  always #2.5 clk = ~clk;

  mbus_target #(
    .NUM_REGS (8),
    .MEM_BASE (MEM_BASE),
    .IO_BASE  (IO_BASE)
  ) u0 (
    .clk(clk), .rstN(rstN), .frameN(frameN), .irdyN(irdyN), .idsel(idsel),
    .adIn(adIn), .cbeN(cbeN), .devselN(devselN), .trdyN(trdyN), .stopN(stopN),
    .ctlOe(ctlOe), .adOut(adOut), .adOe(adOe)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] d,
                                        input logic [3:0] beN);
    logic [31:0] r = old;
    for (int k = 0; k < 4; k++) if (!beN[k]) r[8*k +: 8] = d[8*k +: 8];
    return r;
  endfunction

  // full transaction; waitAt = phase index preceded by a wait clock (-1 none)
  task automatic burst(input logic [3:0] cmd, input logic [31:0] addr, input logic sel,
                       input int n, input logic [31:0] seed, input logic [3:0] be,
                       input int waitAt, input int startIdx, input string req);
    bit rd = (cmd[0] == 1'b0);
    @(negedge clk);
    frameN = 1'b0; irdyN = 1'b1; adIn = addr; cbeN = cmd; idsel = sel;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i == waitAt) begin
        adIn = 32'hDEAD_BEEF; cbeN = 4'h0; irdyN = 1'b1; frameN = 1'b0;
        @(negedge clk);
        chk(!trdyN && !devselN, "R7", "ready held in wait", {30'd0, trdyN, devselN}, 32'd0);
        if (rd) chk(adOut == model[startIdx+i], "R7", "read data in wait", adOut, model[startIdx+i]);
      end
      chk(!devselN && !trdyN, req, "claimed phase", {30'd0, devselN, trdyN}, 32'd0);
      if (rd) begin
        chk(adOe && adOut == model[startIdx+i], "R6", "read data", adOut, model[startIdx+i]);
        adIn = 32'h0; cbeN = 4'h0;
      end else begin
        model[startIdx+i] = merge(model[startIdx+i], seed + i, be);
        adIn = seed + i; cbeN = be;
      end
      idsel = 1'b0; irdyN = 1'b0; frameN = (i == n - 1);
    end
    @(negedge clk);
    chk(devselN && trdyN && stopN && ctlOe, "R10", "driven inactive",
        {28'd0, devselN, trdyN, stopN, ctlOe}, 32'hF);
    irdyN = 1'b1; frameN = 1'b1; cbeN = 4'hF;
    @(negedge clk);
    chk(!ctlOe && !adOe, "R10", "released", {30'd0, ctlOe, adOe}, 32'd0);
  endtask

  // single-phase write cycle that must not be claimed
  task automatic ignored(input logic [3:0] cmd, input logic [31:0] addr, input logic sel,
                         input string req);
    @(negedge clk);
    frameN = 1'b0; irdyN = 1'b1; adIn = addr; cbeN = cmd; idsel = sel;
    @(negedge clk);
    chk(!ctlOe && devselN, req, "not claimed", {30'd0, ctlOe, devselN}, 32'd1);
    adIn = 32'hFFFF_FFFF; cbeN = 4'h0; irdyN = 1'b0; frameN = 1'b1; idsel = 1'b0;
    @(negedge clk);
    chk(!ctlOe, req, "still idle", {31'd0, ctlOe}, 32'd0);
    irdyN = 1'b1; cbeN = 4'hF;
  endtask

  task automatic readAll(input string req);
    burst(4'b0110, MEM_BASE, 1'b0, 8, 32'd0, 4'h0, -1, 0, req);
  endtask

  task automatic testReset;
    chk(!ctlOe && !adOe && devselN && trdyN && stopN, "R1", "in reset",
        {27'd0, ctlOe, adOe, devselN, trdyN, stopN}, 32'h7);
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(!ctlOe && !adOe && devselN && trdyN && stopN, "R1", "after reset",
        {27'd0, ctlOe, adOe, devselN, trdyN, stopN}, 32'h7);
  endtask

  task automatic testMemBurst;
    burst(4'b0111, MEM_BASE, 1'b0, 4, 32'h1111_0000, 4'h0, -1, 0, "R2");
    burst(4'b0110, MEM_BASE, 1'b0, 4, 32'd0, 4'h0, 2, 0, "R8");
  endtask

  task automatic testIoPartial;
    // byte address 0x...07: low bits ignored, register 1; lanes 0 and 2
    burst(4'b0011, IO_BASE + 32'h7, 1'b0, 1, 32'hA5B6_C7D8, 4'b1010, -1, 1, "R3");
    burst(4'b1010, 32'h0000_0004, 1'b1, 1, 32'd0, 4'h0, -1, 1, "R5");
  endtask

  task automatic testCfgWait;
    burst(4'b1011, 32'h0000_0008, 1'b1, 3, 32'h5000_0000, 4'h0, 1, 2, "R4");
    readAll("R7");
  endtask

  task automatic testIgnored;
    ignored(4'b0111, MEM_BASE + 32'h20, 1'b0, "R2");
    ignored(4'b1011, 32'h0000_0000, 1'b0, "R4");
    ignored(4'b0000, MEM_BASE, 1'b1, "R11");
    readAll("R11");
  endtask

  task automatic testStop;
    @(negedge clk);
    frameN = 1'b0; irdyN = 1'b1; adIn = MEM_BASE + 32'h18; cbeN = 4'b0111;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      chk(!trdyN && stopN, "R9", "phase before end", {30'd0, trdyN, stopN}, 32'd1);
      model[6+i] = 32'h7700_0000 + i;
      adIn = 32'h7700_0000 + i; cbeN = 4'h0; irdyN = 1'b0; frameN = 1'b0;
    end
    @(negedge clk);
    chk(!stopN && trdyN && !devselN, "R9", "stop asserted",
        {29'd0, stopN, trdyN, devselN}, 32'd2);
    adIn = 32'hAAAA_AAAA;
    @(negedge clk);
    chk(!stopN && trdyN, "R9", "stop held", {30'd0, stopN, trdyN}, 32'd1);
    frameN = 1'b1;
    @(negedge clk);
    chk(stopN && devselN && ctlOe, "R10", "after stop", {29'd0, stopN, devselN, ctlOe}, 32'd7);
    irdyN = 1'b1; cbeN = 4'hF;
    @(negedge clk);
    chk(!ctlOe, "R10", "released after stop", {31'd0, ctlOe}, 32'd0);
    readAll("R9");
  endtask

  initial begin
    for (int i = 0; i < 8; i++) model[i] = 32'd0;
    @(negedge clk);
    testReset();
    testMemBurst();
    testIoPartial();
    testCfgWait();
    testIgnored();
    testStop();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      nTests++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFails);
      $finish;
    end
  end

endmodule